// File: doc/BRIEF.md
# Level-Sensitive Interrupt Controller with Register Port

This block collects up to 32 level-sensitive interrupt requests, records them in a cause register and enables each one through a mask register. A single registered interrupt line goes to a parent controller. It is high while any source is both recorded and enabled.

Software reads the cause register to see which requests are recorded. It clears a request by writing a one to that bit. Because every source is level-sensitive, a bit that is cleared while its input is still high is recorded again on the next clock. A read-only pending register gives the number of the lowest-numbered source that is both recorded and enabled, or a "none" flag. A handler can therefore dispatch without scanning the bits.

Access is through a plain single-cycle port:
- a byte address,
- a write strobe,
- 32-bit write data,
- 32-bit read data that is combinational from the address.

To shut the controller down, software writes zero to the mask and then all ones to the cause register.

Top module: `lvl_irq_ctl`

## Requirements
- R1: After reset the mask register and the cause register are 0, irq_o is low, and the pending register reads 0x8000_0000.
- R2: The register offsets are 0x0 for cause, 0x4 for mask and 0x8 for pending, and bit n of each register belongs to source n. Reads at any other offset return 0, and writes there change no state.
- R3: Writing the cause register with a 1 in bit n clears cause bit n on that clock edge. A 0 in bit n leaves cause bit n unchanged.
- R4: A high src_i[n] sets cause bit n on the next edge. This holds even when the same edge carries a write-1 clear of that bit, because setting wins over clearing.
- R5: The mask register can be read and written in all 32 bits. A source whose mask bit is 0 cannot raise irq_o.
- R6: irq_o is a register. After every edge it equals the OR of (cause AND mask) as those registers stand after that same edge.
- R7: When (cause AND mask) is nonzero, the pending register returns the lowest set bit index in bits [4:0] and returns 0 in all other bits.
- R8: When (cause AND mask) is zero, the pending register returns 0x8000_0000.
- R9: Writes to the pending register are ignored.
- R10: After a quiesce sequence (mask written with 0, then cause written with all ones), irq_o is low, the pending register reads 0x8000_0000 and the mask reads 0. This holds whatever the source inputs are doing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Level interrupt requests, one per source |
| addr_i | input | 4 | Byte address of the register access |
| we_i | input | 1 | Write strobe, taken on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered combined interrupt to the parent controller |

## Verification
The assertions assume the following about the inputs:
- src_i, addr_i, we_i and wdata_i are stable around each rising edge.
- A write applies for exactly the cycle in which we_i is high.

The bench meets this by changing every input on the falling edge only. It reads rdata_o one nanosecond after setting the address, well away from the next rising edge.

Source pulses last one clock, so the cause bits hold only what the bench placed there. The exception is the set-over-clear and quiesce cases, where a source is deliberately held high across an acknowledge.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DATA_W    = 32;
  localparam int OFS_CAUSE = 'h0;
  localparam int OFS_MASK  = 'h4;
  localparam int OFS_PEND  = 'h8;
  localparam int NONE_BIT  = 31;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CAUSE,
    SEL_MASK,
    SEL_PEND
  } reg_sel_e;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] ack_i,
  output logic [NUM_SRC-1:0] cause_d_o,
  output logic [NUM_SRC-1:0] cause_q_o
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // level set wins over write-1 clear
    assign cause_d_o[i] = src_i[i] | (cause_q_o[i] & ~ack_i[i]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q_o[i] <= 1'b0;
      else         cause_q_o[i] <= cause_d_o[i];
    end
  end

  // R4
  src_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_q_o & $past(src_i)) == $past(src_i)));
  // R3
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(ack_i & ~src_i)) |=> ((cause_q_o & $past(ack_i & ~src_i)) == '0));
  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i == '0 && src_i == '0) |=> $stable(cause_q_o));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] active_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               none_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign none_o = ~|active_i;

  // R7
  lowest_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !none_o |-> (active_i[idx_o] &&
                 ((active_i & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0)));
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [NUM_SRC-1:0] cause_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [IDX_W-1:0]   pend_idx_i,
  input  logic               pend_none_i,
  output logic               cause_we_o,
  output logic               mask_we_o,
  output logic [DATA_W-1:0]  rdata_o
);
  reg_sel_e sel;

  always_comb begin
    if      (addr_i == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
    else if (addr_i == ADDR_W'(OFS_MASK))  sel = SEL_MASK;
    else if (addr_i == ADDR_W'(OFS_PEND))  sel = SEL_PEND;
    else                                   sel = SEL_NONE;
  end

  // pending register is read-only
  assign cause_we_o = we_i && (sel == SEL_CAUSE);
  assign mask_we_o  = we_i && (sel == SEL_MASK);

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CAUSE: rdata_o[NUM_SRC-1:0] = cause_i;
      SEL_MASK:  rdata_o[NUM_SRC-1:0] = mask_i;
      SEL_PEND: begin
        rdata_o[NONE_BIT]    = pend_none_i;
        rdata_o[IDX_W-1:0]   = pend_idx_i;
      end
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lvl_irq_ctl.sv
module lvl_irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 4,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] cause_d, cause_q, mask_d, mask_q, ack;
  logic [IDX_W-1:0]   pend_idx;
  logic               pend_none, cause_we, mask_we, irq_q;

  assign ack    = cause_we ? wdata_i[NUM_SRC-1:0] : '0;
  assign mask_d = mask_we  ? wdata_i[NUM_SRC-1:0] : mask_q;

  irq_cause_bank #(.NUM_SRC(NUM_SRC)) u_cause (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (src_i),
    .ack_i    (ack),
    .cause_d_o(cause_d),
    .cause_q_o(cause_q)
  );

  irq_prio_enc #(.NUM_SRC(NUM_SRC)) u_prio (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(cause_q & mask_q),
    .idx_o   (pend_idx),
    .none_o  (pend_none)
  );

  irq_reg_port #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_port (
    .addr_i     (addr_i),
    .we_i       (we_i),
    .cause_i    (cause_q),
    .mask_i     (mask_q),
    .pend_idx_i (pend_idx),
    .pend_none_i(pend_none),
    .cause_we_o (cause_we),
    .mask_we_o  (mask_we),
    .rdata_o    (rdata_o)
  );

  // irq computed from next state so it lines up with the registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      irq_q  <= |(cause_d & mask_d);
    end
  end

  assign irq_o = irq_q;

  // R6
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == |(cause_q & mask_q)));
  // R5
  mask_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we |=> (mask_q == $past(wdata_i[NUM_SRC-1:0])));
  // R9
  mask_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we |=> $stable(mask_q));
endmodule

// File: tb/lvl_irq_ctl_tb.sv
module lvl_irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lvl_irq_ctl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  localparam logic [3:0]  A_CAUSE = 4'h0, A_MASK = 4'h4, A_PEND = 4'h8;
  localparam logic [31:0] NONE = 32'h8000_0000;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk);
    src = s;
    @(negedge clk);
    src = '0;
  endtask

  function automatic logic [31:0] pend_of(input logic [31:0] act);
    pend_of = NONE;
    for (int i = 31; i >= 0; i--) if (act[i]) pend_of = 32'(i);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CAUSE, d); chk("R1 cause", d, 0);
    rd(A_MASK, d);  chk("R1 mask", d, 0);
    rd(A_PEND, d);  chk("R1 pend", d, NONE);
    chk("R1 irq", 32'(irq), 0);

    // R5 disabled source cannot raise irq
    pulse(32'h1);
    chk("R5 masked irq", 32'(irq), 0);
    rd(A_PEND, d); chk("R8 masked pend", d, NONE);
    wr(A_CAUSE, 32'h1);

    // R2/R3/R6/R7 per-bit sweep
    wr(A_MASK, '1);
    rd(A_MASK, d); chk("R5 mask all ones", d, '1);
    for (int n = 0; n < 32; n++) begin
      pulse(32'h1 << n);
      rd(A_CAUSE, d); chk("R2 cause bit", d, 32'h1 << n);
      rd(A_PEND, d);  chk("R7 pend idx", d, 32'(n));
      chk("R6 irq high", 32'(irq), 1);
      wr(A_CAUSE, 32'h1 << n);
      rd(A_CAUSE, d); chk("R3 ack clears", d, 0);
      rd(A_PEND, d);  chk("R8 pend none", d, NONE);
      chk("R6 irq low", 32'(irq), 0);
    end

    // R7 priority: all bits at and above n recorded
    for (int n = 0; n < 32; n++) begin
      pulse(~((32'h1 << n) - 32'h1));
      rd(A_PEND, d); chk("R7 lowest wins", d, pend_of(~((32'h1 << n) - 32'h1)));
      wr(A_CAUSE, '1);
    end

    // R5/R7 mask sweep with every cause bit recorded
    pulse('1);
    for (int m = 0; m < 32; m++) begin
      wr(A_MASK, 32'h1 << m);
      chk("R6 irq follows mask", 32'(irq), 1);
      rd(A_MASK, d); chk("R5 mask rw", d, 32'h1 << m);
      rd(A_PEND, d); chk("R7 masked select", d, 32'(m));
    end
    wr(A_MASK, 32'hA5A5_5A5A);
    rd(A_MASK, d); chk("R5 mask pattern", d, 32'hA5A5_5A5A);
    rd(A_PEND, d); chk("R7 pattern pend", d, pend_of(32'hA5A5_5A5A));
    wr(A_MASK, 32'h0);
    chk("R6 irq after mask off", 32'(irq), 0);

    // R3 write 0 leaves bits
    wr(A_CAUSE, '1);
    pulse(32'h0000_00F0);
    wr(A_CAUSE, 32'h0000_0030);
    rd(A_CAUSE, d); chk("R3 partial ack", d, 32'h0000_00C0);
    wr(A_CAUSE, 32'h0);
    rd(A_CAUSE, d); chk("R3 zero write", d, 32'h0000_00C0);

    // R2/R9 unmapped and pending writes ignored
    wr(A_MASK, 32'h0000_0F00);
    wr(4'hC, '1);
    rd(4'hC, d);    chk("R2 unmapped read", d, 0);
    rd(A_MASK, d);  chk("R2 unmapped mask kept", d, 32'h0000_0F00);
    rd(A_CAUSE, d); chk("R2 unmapped cause kept", d, 32'h0000_00C0);
    wr(A_PEND, '1);
    rd(A_MASK, d);  chk("R9 mask kept", d, 32'h0000_0F00);
    rd(A_CAUSE, d); chk("R9 cause kept", d, 32'h0000_00C0);
    rd(A_PEND, d);  chk("R9 pend", d, NONE);
    wr(A_CAUSE, '1);

    // R4 set wins over clear while held
    wr(A_MASK, '1);
    @(negedge clk); src = 32'h20;
    wr(A_CAUSE, 32'h20);
    rd(A_CAUSE, d); chk("R4 set over clear", d, 32'h20);
    chk("R4 irq stays", 32'(irq), 1);
    src = '0;
    wr(A_CAUSE, 32'h20);
    rd(A_CAUSE, d); chk("R4 clear after release", d, 0);

    // R10 quiesce with sources held high
    @(negedge clk); src = 32'h0001_8001;
    wr(A_MASK, 32'h0);
    wr(A_CAUSE, '1);
    chk("R10 irq", 32'(irq), 0);
    rd(A_PEND, d);  chk("R10 pend", d, NONE);
    rd(A_MASK, d);  chk("R10 mask", d, 0);
    rd(A_CAUSE, d); chk("R4 level reasserts", d, 32'h0001_8001);
    src = '0;
    wr(A_CAUSE, '1);
    rd(A_CAUSE, d); chk("R10 cause clear", d, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule